// File: doc/BRIEF.md
# Event Counter Unit with Latency Accumulation and Drain Flush

The unit keeps a small bank of wide hardware counters for monitoring traffic in a shared fabric block. Each counter is steered by an 8-bit event code. Low codes pick a single-cycle occurrence pulse from an input bus, and the counter adds one for each cycle that pulse is high. A second range of codes picks one of several in-flight request counts, and the counter adds that count every cycle. This turns the counter into a sum of latency over all requests of that class.

Software controls the unit through a 32-bit write/read register port. The registers cover a global run bit, per-counter enables, event selection, counter preload and readback, and overflow interrupts that are masked and cleared per counter. When counting stops, some latency-class requests may still be outstanding. Software then issues a flush command. The flush bit stays set, and enabled latency counters keep accumulating, until every in-flight count is zero. The bit then clears by itself, and software knows the totals are final.

Top module: `evt_count_unit`

## Requirements
- R1: After reset, all counters read 0, the run bit, counter enables, event selects, status and flush bit read 0, every mask bit reads 1, and `irq` is low.
- R2: A counter whose code is 0x00..0x0E adds 1 on each clock edge where `evt_pulse[code]` is high, provided the run bit and its enable are both set; code 0x0F counts nothing.
- R3: A counter whose code is 0x80+k (k = 0..7) adds lane k of `lat_inflight` (lane k at bits 8k+7:8k) on every clock edge where the run bit and its enable are both set.
- R4: With the run bit (bit 0 at offset 0x00) clear and no flush pending, no counter changes.
- R5: A counter counts only while its own enable bit (bit n of offset 0x04) is set.
- R6: The code of counter n sits in bits 8n+7:8n of the select register at 0x20; any code outside 0x00..0x0E and 0x80..0x87 counts nothing.
- R7: Counter n reads and preloads its low 32 bits at 0x40+8n and its upper 16 bits at 0x44+8n (upper write data bits are dropped). A preload takes priority over an increment in the same cycle.
- R8: An increment that carries a counter past 2^48-1 wraps it and sets status bit n (offset 0x10). Writing 1 to bit n of offset 0x14 clears that bit, and a new wrap in the same cycle wins over the clear.
- R9: `irq` is high exactly when some status bit is set whose mask bit (offset 0x0C, 1 = masked) is 0.
- R10: Writing 1 to bit 0 of offset 0x08 starts a flush. The bit reads 1 until the first clock edge at which all lanes of `lat_inflight` are zero, and reads 0 after that edge. While it is pending, enabled latency counters accumulate even with the run bit clear. Occurrence counters do not. Writing 0 has no effect.
- R11: Offset 0x18 reads the fixed version parameter, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_pulse | input | 15 | Occurrence pulses, bit c for code c |
| lat_inflight | input | 64 | Eight 8-bit counts of outstanding requests per latency class |
| irq | output | 1 | Unmasked overflow interrupt |

## Verification
The properties assume that `bus_addr` and `bus_wdata` matter only in a cycle with `bus_wen` high. They also assume that `lat_inflight` eventually returns to zero, so a flush cannot stay pending forever. The bench changes inputs only at falling edges and pulses `bus_wen` for exactly one cycle per write. Each flush scenario ends by driving every in-flight lane to zero, so the drain condition is always reached.

// File: rtl/upmu_pkg.sv
package upmu_pkg;

  localparam int NUM_OCC = 15;
  localparam int NUM_LAT = 8;
  localparam logic [7:0] OCC_LAST = 8'h0E;
  localparam logic [7:0] LAT_BASE = 8'h80;

  localparam int OFS_RUN   = 'h00;
  localparam int OFS_CEN   = 'h04;
  localparam int OFS_FLUSH = 'h08;
  localparam int OFS_MASK  = 'h0C;
  localparam int OFS_STAT  = 'h10;
  localparam int OFS_CLR   = 'h14;
  localparam int OFS_VER   = 'h18;
  localparam int OFS_SEL   = 'h20;
  localparam int OFS_CNT   = 'h40;

  typedef enum logic [1:0] {EV_NONE, EV_OCC, EV_LAT} ev_kind_e;

  function automatic ev_kind_e classify(input logic [7:0] code);
    if (code <= OCC_LAST) return EV_OCC;
    if (code >= LAT_BASE && code < LAT_BASE + 8'(NUM_LAT)) return EV_LAT;
    return EV_NONE;
  endfunction

endpackage

// File: rtl/upmu_evt_mux.sv
module upmu_evt_mux
  import upmu_pkg::*;
#(
  parameter int LAT_W = 8
) (
  input  logic [7:0]                   code,
  input  logic [NUM_OCC-1:0]           pulse,
  input  logic [NUM_LAT-1:0][LAT_W-1:0] lat,
  input  logic                         occ_ok,
  input  logic                         lat_ok,
  output logic [LAT_W-1:0]             inc
);
  localparam int LAT_IW = $clog2(NUM_LAT);

  logic [15:0] pulse_pad;
  assign pulse_pad = 16'(pulse);

  always_comb begin
    inc = '0;
    unique case (classify(code))
      EV_OCC:  if (occ_ok && pulse_pad[code[3:0]]) inc = LAT_W'(1);
      EV_LAT:  if (lat_ok) inc = lat[code[LAT_IW-1:0]];
      default: inc = '0;
    endcase
  end
endmodule

// File: rtl/upmu_cnt_slice.sv
module upmu_cnt_slice #(
  parameter int CNT_W = 48,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam int HI_W = CNT_W - 32;
  localparam int SW   = CNT_W + 1;

  function automatic logic [SW-1:0] bump(input logic [CNT_W-1:0] v,
                                         input logic [INC_W-1:0] d);
    return {1'b0, v} + SW'(d);
  endfunction

  logic [SW-1:0] sum;
  assign sum  = bump(cnt, inc);
  assign wrap = sum[CNT_W] && !(wr_lo || wr_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_lo) cnt[31:0] <= wdata;
    else if (wr_hi) cnt[CNT_W-1:32] <= wdata[HI_W-1:0];
    else            cnt <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/upmu_flush.sv
module upmu_flush (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic drained,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend <= 1'b0;
    else if (start)            pend <= 1'b1;
    else if (pend && drained)  pend <= 1'b0;
  end
endmodule

// File: rtl/evt_count_unit.sv
module evt_count_unit
  import upmu_pkg::*;
#(
  parameter int          NUM_CNT = 4,
  parameter int          CNT_W   = 48,
  parameter int          LAT_W   = 8,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] VERSION = 32'h0001_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wen,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NUM_OCC-1:0]       evt_pulse,
  input  logic [NUM_LAT*LAT_W-1:0] lat_inflight,
  output logic                     irq
);
  localparam int NUM_SEL = (NUM_CNT + 3) / 4;
  localparam int HI_W    = CNT_W - 32;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic                               glob_en;
  logic [NUM_CNT-1:0]                 cen;
  logic [NUM_CNT-1:0]                 imask;
  logic [NUM_CNT-1:0]                 istat;
  logic [NUM_CNT-1:0]                 wrap;
  logic [NUM_CNT-1:0]                 stat_clr;
  logic [NUM_CNT-1:0][7:0]            evsel;
  logic [NUM_CNT-1:0][CNT_W-1:0]      cnt_q;
  logic [NUM_LAT-1:0][LAT_W-1:0]      lat_vec;
  logic                               flush_pend;
  logic                               flush_start;
  logic                               drained;

  assign lat_vec     = lat_inflight;
  assign drained     = (lat_inflight == '0);
  assign flush_start = bus_wen && hit(bus_addr, OFS_FLUSH) && bus_wdata[0];
  assign stat_clr    = (bus_wen && hit(bus_addr, OFS_CLR)) ? bus_wdata[NUM_CNT-1:0] : '0;
  assign irq         = |(istat & ~imask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      cen     <= '0;
      imask   <= '1;
      istat   <= '0;
    end else begin
      if (bus_wen && hit(bus_addr, OFS_RUN))  glob_en <= bus_wdata[0];
      if (bus_wen && hit(bus_addr, OFS_CEN))  cen     <= bus_wdata[NUM_CNT-1:0];
      if (bus_wen && hit(bus_addr, OFS_MASK)) imask   <= bus_wdata[NUM_CNT-1:0];
      istat <= (istat & ~stat_clr) | wrap;
    end
  end

  upmu_flush u_flush (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (flush_start),
    .drained (drained),
    .pend    (flush_pend)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [LAT_W-1:0] inc;
    logic             wr_lo;
    logic             wr_hi;

    assign wr_lo = bus_wen && hit(bus_addr, OFS_CNT + 8 * i);
    assign wr_hi = bus_wen && hit(bus_addr, OFS_CNT + 8 * i + 4);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evsel[i] <= '0;
      else if (bus_wen && hit(bus_addr, OFS_SEL + 4 * (i / 4)))
        evsel[i] <= bus_wdata[8 * (i % 4) +: 8];
    end

    upmu_evt_mux #(.LAT_W(LAT_W)) u_mux (
      .code   (evsel[i]),
      .pulse  (evt_pulse),
      .lat    (lat_vec),
      .occ_ok (glob_en && cen[i]),
      .lat_ok (cen[i] && (glob_en || flush_pend)),
      .inc    (inc)
    );

    upmu_cnt_slice #(.CNT_W(CNT_W), .INC_W(LAT_W)) u_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (wr_lo),
      .wr_hi (wr_hi),
      .wdata (bus_wdata),
      .inc   (inc),
      .cnt   (cnt_q[i]),
      .wrap  (wrap[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, OFS_RUN))   bus_rdata[0] = glob_en;
    if (hit(bus_addr, OFS_CEN))   bus_rdata[NUM_CNT-1:0] = cen;
    if (hit(bus_addr, OFS_FLUSH)) bus_rdata[0] = flush_pend;
    if (hit(bus_addr, OFS_MASK))  bus_rdata[NUM_CNT-1:0] = imask;
    if (hit(bus_addr, OFS_STAT))  bus_rdata[NUM_CNT-1:0] = istat;
    if (hit(bus_addr, OFS_VER))   bus_rdata = VERSION;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (hit(bus_addr, OFS_SEL + 4 * k)) begin
        for (int j = 0; j < 4; j++) begin
          if (4 * k + j < NUM_CNT) bus_rdata[8 * j +: 8] = evsel[4 * k + j];
        end
      end
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (hit(bus_addr, OFS_CNT + 8 * i))     bus_rdata = cnt_q[i][31:0];
      if (hit(bus_addr, OFS_CNT + 8 * i + 4)) bus_rdata[HI_W-1:0] = cnt_q[i][CNT_W-1:32];
    end
  end
endmodule

// File: rtl/upmu_chk.sv
module upmu_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 48
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_wen,
  input logic                          glob_en,
  input logic [NUM_CNT-1:0]            cen,
  input logic [NUM_CNT-1:0]            imask,
  input logic [NUM_CNT-1:0]            istat,
  input logic [NUM_CNT-1:0]            wrap,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
  input logic                          flush_pend,
  input logic                          flush_start,
  input logic                          drained,
  input logic                          irq
);
  // R10
  flush_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pend && drained && !flush_start) |=> !flush_pend);

  // R10
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pend && !drained) |=> flush_pend);

  // R10
  flush_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_pend) |-> $past(flush_start));

  // R4
  idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !flush_pend && !bus_wen) |=> $stable(cnt_q));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&imask) |-> !irq);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_per
    // R5
    off_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen[i] && !bus_wen) |=> $stable(cnt_q[i]));

    // R8
    wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[i] |=> istat[i]);

    // R8
    stat_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(istat[i]) |-> $past(wrap[i]));
  end
endmodule

bind evt_count_unit upmu_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wen     (bus_wen),
  .glob_en     (glob_en),
  .cen         (cen),
  .imask       (imask),
  .istat       (istat),
  .wrap        (wrap),
  .cnt_q       (cnt_q),
  .flush_pend  (flush_pend),
  .flush_start (flush_start),
  .drained     (drained),
  .irq         (irq)
);

// File: tb/tb_evt_count_unit.sv
module tb_evt_count_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VER = 32'h0001_0000;

  localparam logic [7:0] A_RUN = 8'h00, A_CEN = 8'h04, A_FLUSH = 8'h08, A_MASK = 8'h0C;
  localparam logic [7:0] A_STAT = 8'h10, A_CLR = 8'h14, A_VER = 8'h18, A_SEL = 8'h20;

  // code, cycles, lat base, counter, pulse mask, expected
  localparam int NV = 9;
  localparam logic [79:0] VEC [NV] = '{
    {8'h00, 8'd5, 8'd0,  8'd0, 16'h0001, 32'd5},
    {8'h0E, 8'd7, 8'd0,  8'd1, 16'h4000, 32'd7},
    {8'h05, 8'd4, 8'd0,  8'd2, 16'h7FDF, 32'd0},
    {8'h80, 8'd3, 8'd4,  8'd3, 16'h0000, 32'd12},
    {8'h87, 8'd2, 8'd10, 8'd0, 16'h0000, 32'd34},
    {8'h83, 8'd6, 8'd1,  8'd1, 16'h7FFF, 32'd24},
    {8'h40, 8'd5, 8'd9,  8'd2, 16'h7FFF, 32'd0},
    {8'h88, 8'd5, 8'd9,  8'd3, 16'h7FFF, 32'd0},
    {8'h0F, 8'd3, 8'd9,  8'd0, 16'h7FFF, 32'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [14:0] evt_pulse = '0;
  logic [63:0] lat_inflight = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  evt_count_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .lat_inflight(lat_inflight), .irq(irq)
  );

  function automatic logic [7:0] lo_a(input int n); return 8'(8'h40 + 8 * n); endfunction
  function automatic logic [7:0] hi_a(input int n); return 8'(8'h44 + 8 * n); endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic drive(input logic [14:0] pm, input logic [7:0] lv);
    evt_pulse = pm;
    for (int k = 0; k < 8; k++)
      lat_inflight[8 * k +: 8] = (lv == 0) ? 8'd0 : 8'(lv + k);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_RUN, d);   chk("R1 run", d, 0);
    rd(A_CEN, d);   chk("R1 cen", d, 0);
    rd(A_FLUSH, d); chk("R1 flush", d, 0);
    rd(A_MASK, d);  chk("R1 mask", d, 32'hF);
    rd(A_STAT, d);  chk("R1 stat", d, 0);
    rd(A_SEL, d);   chk("R1 sel", d, 0);
    rd(lo_a(3), d); chk("R1 cnt", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    // R11 version fixed
    rd(A_VER, d);   chk("R11 ver", d, VER);
    wr(A_VER, 32'h1234_5678);
    rd(A_VER, d);   chk("R11 ver write ignored", d, VER);

    // table walk: R2, R3, R6
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  code, cyc, lv;
      int          idx;
      logic [15:0] pm;
      logic [31:0] exp, sel;
      string       tag;
      code = VEC[v][79:72]; cyc = VEC[v][71:64]; lv = VEC[v][63:56];
      idx = int'(VEC[v][55:48]); pm = VEC[v][47:32]; exp = VEC[v][31:0];
      if (code <= 8'h0E) tag = "R2 occurrence";
      else if (code >= 8'h80 && code <= 8'h87) tag = "R3 latency";
      else tag = "R6 unused code";
      sel = 32'hFFFF_FFFF;
      sel[8 * idx +: 8] = code;
      wr(A_RUN, 0);
      wr(lo_a(idx), 0);
      wr(hi_a(idx), 0);
      wr(A_SEL, sel);
      wr(A_CEN, 32'(1 << idx));
      wr(A_RUN, 1);
      drive(pm[14:0], lv);
      repeat (int'(cyc)) @(negedge clk);
      drive('0, 0);
      rd(lo_a(idx), d);
      chk(tag, d, exp);
    end

    // R6 byte lane readback
    wr(A_SEL, 32'h8300_0E05);
    rd(A_SEL, d); chk("R6 sel lanes", d, 32'h8300_0E05);

    // R4 run bit clear stops counting
    wr(A_RUN, 0);
    wr(A_SEL, 0);
    wr(A_CEN, 32'hF);
    wr(lo_a(0), 0);
    drive(15'h0001, 0);
    repeat (5) @(negedge clk);
    drive('0, 0);
    rd(lo_a(0), d); chk("R4 run off", d, 0);

    // R5 per-counter enable
    wr(lo_a(1), 0);
    wr(hi_a(1), 0);
    wr(A_CEN, 32'h1);
    wr(A_RUN, 1);
    drive(15'h0001, 0);
    repeat (4) @(negedge clk);
    drive('0, 0);
    rd(lo_a(0), d); chk("R5 enabled", d, 4);
    rd(lo_a(1), d); chk("R5 disabled", d, 0);

    // R7 preload and readback
    wr(lo_a(2), 32'hDEAD_BEEF);
    wr(hi_a(2), 32'hABCD_1234);
    rd(lo_a(2), d); chk("R7 lo", d, 32'hDEAD_BEEF);
    rd(hi_a(2), d); chk("R7 hi", d, 32'h0000_1234);
    // R7 write wins over increment
    @(negedge clk);
    evt_pulse = 15'h0001;
    bus_wen = 1'b1; bus_addr = lo_a(0); bus_wdata = 32'd100;
    @(negedge clk);
    bus_wen = 1'b0;
    evt_pulse = '0;
    rd(lo_a(0), d); chk("R7 priority", d, 100);

    // R8, R9 wrap, status, irq
    wr(hi_a(0), 32'h0000_FFFF);
    wr(lo_a(0), 32'hFFFF_FFFE);
    drive(15'h0001, 0);
    repeat (3) @(negedge clk);
    drive('0, 0);
    rd(lo_a(0), d); chk("R8 wrap lo", d, 1);
    rd(hi_a(0), d); chk("R8 wrap hi", d, 0);
    rd(A_STAT, d);  chk("R8 status set", d, 1);
    chk("R9 masked irq", {31'b0, irq}, 0);
    wr(A_MASK, 32'hE);
    chk("R9 unmasked irq", {31'b0, irq}, 1);
    wr(A_CLR, 32'h1);
    rd(A_STAT, d);  chk("R8 status clear", d, 0);
    chk("R9 irq after clear", {31'b0, irq}, 0);

    // R10 flush drain
    wr(A_RUN, 0);
    wr(A_SEL, 32'h0080_FFFF);
    wr(A_CEN, 32'hC);
    wr(lo_a(2), 0);
    wr(hi_a(2), 0);
    wr(lo_a(3), 0);
    drive(15'h7FFF, 3);
    wr(A_FLUSH, 0);
    rd(A_FLUSH, d); chk("R10 zero write ignored", d, 0);
    wr(A_FLUSH, 1);
    rd(A_FLUSH, d); chk("R10 pending", d, 1);
    repeat (4) @(negedge clk);
    drive('0, 0);
    rd(A_FLUSH, d); chk("R10 still pending", d, 1);
    @(negedge clk);
    rd(A_FLUSH, d); chk("R10 self clear", d, 0);
    rd(lo_a(2), d); chk("R10 latency accumulated", d, 12);
    rd(lo_a(3), d); chk("R10 occurrence held", d, 0);
    // R10 flush with nothing outstanding
    wr(A_FLUSH, 1);
    rd(A_FLUSH, d); chk("R10 idle pending", d, 1);
    @(negedge clk);
    rd(A_FLUSH, d); chk("R10 idle clear", d, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule